// File: doc/BRIEF.md
# Subcode Serial Word Transmitter

This block takes 7-bit subcode symbols (channels Q through W) from an upstream decoder and sends each one on a single output line as a self-framed serial word. The line rests low. A word opens with a high marker and then carries the channel bits, Q first and W last, one bit cell each. When a symbol is flagged as the block-sync position, its marker lasts two cells instead of one, so a receiver can find where a subcode block begins.

All timing comes from clock counts, divided by a 2-bit speed setting that selects 1x, 2x, 4x or 8x playback. A bit cell lasts `CELL_BASE >> spd` clocks. Word starts are spaced `WORD_BASE >> spd` clocks apart. With the defaults (16 and 224), one word slot is 14 cells: a normal word uses 8 of them and a sync word uses 9. This keeps the low gap to a bounded share of the slot.

A symbol that arrives while a word is still being sent waits in a one-entry hold register. If a further symbol arrives while that register is occupied, the new symbol is dropped and a sticky overrun flag is raised.

The sequencer has four states:

- **ST_IDLE**: the line is low.
- **ST_MARK**: the marker is being sent.
- **ST_DATA**: the seven channel bits are being sent.
- **ST_GAP**: the line is low until the slot ends.

Its transitions are:

- **IDLE→MARK**: a held symbol is present.
- **MARK→DATA**: the marker length has elapsed.
- **DATA→GAP**: the last cell of the W bit has ended.
- **GAP→MARK**: the slot has ended and another symbol is held.
- **GAP→IDLE**: the slot has ended and nothing is held.

Top module: `subcode_word_tx`

## Requirements
- R1: After reset, `sdo`, `busy` and `ovr` are low, and `sdo` stays low whenever `busy` is low.
- R2: With the sequencer idle, a symbol strobed in the cycle before clock edge k starts its word at edge k+1. From that edge, `sdo` is high (marker) and `busy` is high.
- R3: The channel bits follow the marker in the order `sym_bits[6]` (Q), `[5]` (R), `[4]` (S), `[3]` (T), `[2]` (U), `[1]` (V), `[0]` (W). Each bit holds `sdo` for one whole cell.
- R4: A bit cell lasts `CELL_BASE >> spd` clocks, with `spd` = 0, 1, 2 or 3 meaning 1x, 2x, 4x or 8x. The speed is taken at the start of each word.
- R5: A symbol strobed with `sym_sync` low has a one-cell marker. A symbol strobed with `sym_sync` high has a two-cell marker.
- R6: After the W bit, `sdo` is low for the rest of the slot. When a symbol is waiting, consecutive words start exactly `WORD_BASE >> spd` clocks apart.
- R7: A symbol strobed while a word is being sent is held and then sent as the next word, unchanged.
- R8: A strobe that arrives while the hold register is full and is not being emptied in that cycle is discarded, and it sets `ovr`. `ovr` then stays high until reset.
- R9: `busy` stays high from the first marker cycle until the end of the word slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_vld | input | 1 | One-cycle strobe: a new symbol is present |
| sym_bits | input | 7 | Channel bits; bit 6 is Q, bit 0 is W |
| sym_sync | input | 1 | The symbol is at the block-sync position |
| spd | input | 2 | Speed select: 0=1x, 1=2x, 2=4x, 3=8x |
| sdo | output | 1 | Serial line, low when idle |
| busy | output | 1 | A word slot is in progress |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The assertions check the following on every cycle:

- the line is low whenever no slot is active;
- every new slot opens with the marker high;
- the overrun flag never drops and only rises after a strobe;
- two word starts are never closer together than the shortest slot.

Only the bench scenarios can show the rest: the exact bit order, the cell length and the marker length at each speed, the exact slot spacing for back-to-back symbols, and that an overrun drops the newest symbol while keeping the held one.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

    localparam int unsigned SYM_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_DATA,
        ST_GAP
    } sctx_state_e;

    typedef struct packed {
        logic             sync;
        logic [SYM_W-1:0] bits;
    } sctx_sym_t;

endpackage

// File: rtl/sctx_timebase.sv
module sctx_timebase #(
    parameter int unsigned CELL_BASE = 16,
    parameter int unsigned WORD_BASE = 224,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned SPD_W     = 2
) (
    input  logic [SPD_W-1:0] spd,
    output logic [CNT_W-1:0] cell_len,
    output logic [CNT_W-1:0] word_len
);
    localparam int unsigned N_SPD = 1 << SPD_W;

    logic [CNT_W-1:0] cell_tab [N_SPD];
    logic [CNT_W-1:0] word_tab [N_SPD];

    // One entry per speed setting: each step halves every interval.
    for (genvar g = 0; g < N_SPD; g++) begin : g_speed
        assign cell_tab[g] = CNT_W'(CELL_BASE >> g);
        assign word_tab[g] = CNT_W'(WORD_BASE >> g);
    end

    assign cell_len = cell_tab[spd];
    assign word_len = word_tab[spd];

endmodule

// File: rtl/sctx_holdbuf.sv
module sctx_holdbuf
    import sctx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  sctx_sym_t din,
    input  logic      pop,
    output logic      full,
    output sctx_sym_t dout,
    output logic      ovr
);
    logic accept;

    // A write is taken when the slot is free or is being emptied in this cycle.
    assign accept = wr && (!full || pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
            ovr  <= 1'b0;
        end else begin
            if (accept) begin
                dout <= din;
                full <= 1'b1;
            end else if (pop) begin
                full <= 1'b0;
            end
            if (wr && !accept) begin
                ovr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sctx_fsm.sv
module sctx_fsm
    import sctx_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_full,
    input  sctx_sym_t        buf_dat,
    input  logic [CNT_W-1:0] cell_len,
    input  logic [CNT_W-1:0] word_len,
    output logic             pop,
    output logic             sdo,
    output logic             busy
);
    localparam int unsigned IDX_W = $clog2(SYM_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYM_W - 1);

    sctx_state_e      state_q, state_d;
    logic [CNT_W-1:0] cell_cnt_q, slot_cnt_q, mark_end_q, cell_len_q, word_len_q;
    logic [IDX_W-1:0] bit_idx_q;
    logic [SYM_W-1:0] shreg_q;
    logic             load, cell_end, mark_end, slot_end;

    assign cell_end = (cell_cnt_q == cell_len_q - 1'b1);
    assign mark_end = (cell_cnt_q == mark_end_q - 1'b1);
    assign slot_end = (slot_cnt_q == word_len_q - 1'b1);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (buf_full) begin
                    load    = 1'b1;
                    state_d = ST_MARK;
                end
            end
            ST_MARK: begin
                if (mark_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (cell_end && bit_idx_q == LAST_IDX) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (slot_end) begin
                    if (buf_full) begin
                        load    = 1'b1;
                        state_d = ST_MARK;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_cnt_q <= '0;
            slot_cnt_q <= '0;
            mark_end_q <= '0;
            cell_len_q <= '0;
            word_len_q <= '0;
            bit_idx_q  <= '0;
            shreg_q    <= '0;
        end else if (load) begin
            cell_cnt_q <= '0;
            slot_cnt_q <= '0;
            bit_idx_q  <= '0;
            shreg_q    <= buf_dat.bits;
            cell_len_q <= cell_len;
            word_len_q <= word_len;
            mark_end_q <= buf_dat.sync ? (cell_len << 1) : cell_len;
        end else begin
            unique case (state_q)
                ST_MARK: begin
                    slot_cnt_q <= slot_cnt_q + 1'b1;
                    cell_cnt_q <= mark_end ? '0 : cell_cnt_q + 1'b1;
                end
                ST_DATA: begin
                    slot_cnt_q <= slot_cnt_q + 1'b1;
                    if (cell_end) begin
                        cell_cnt_q <= '0;
                        bit_idx_q  <= bit_idx_q + 1'b1;
                        shreg_q    <= shreg_q << 1;
                    end else begin
                        cell_cnt_q <= cell_cnt_q + 1'b1;
                    end
                end
                ST_GAP: slot_cnt_q <= slot_cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pop  = load;
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_MARK: sdo = 1'b1;
            ST_DATA: sdo = shreg_q[SYM_W-1];
            default: sdo = 1'b0;
        endcase
    end

endmodule

// File: rtl/subcode_word_tx.sv
module subcode_word_tx
    import sctx_pkg::*;
#(
    parameter int unsigned CELL_BASE = 16,
    parameter int unsigned WORD_BASE = 224,
    parameter int unsigned SPD_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_vld,
    input  logic [SYM_W-1:0] sym_bits,
    input  logic             sym_sync,
    input  logic [SPD_W-1:0] spd,
    output logic             sdo,
    output logic             busy,
    output logic             ovr
);
    localparam int unsigned CNT_W = $clog2(WORD_BASE + 1);

    sctx_sym_t        in_sym, held_sym;
    logic             held_full, fsm_pop;
    logic [CNT_W-1:0] cell_len, word_len;

    assign in_sym.sync = sym_sync;
    assign in_sym.bits = sym_bits;

    sctx_timebase #(
        .CELL_BASE (CELL_BASE),
        .WORD_BASE (WORD_BASE),
        .CNT_W     (CNT_W),
        .SPD_W     (SPD_W)
    ) u_timebase (
        .spd      (spd),
        .cell_len (cell_len),
        .word_len (word_len)
    );

    sctx_holdbuf u_holdbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (sym_vld),
        .din   (in_sym),
        .pop   (fsm_pop),
        .full  (held_full),
        .dout  (held_sym),
        .ovr   (ovr)
    );

    sctx_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_full (held_full),
        .buf_dat  (held_sym),
        .cell_len (cell_len),
        .word_len (word_len),
        .pop      (fsm_pop),
        .sdo      (sdo),
        .busy     (busy)
    );

endmodule

// File: rtl/sctx_checker.sv
module sctx_checker #(
    parameter int unsigned WORD_BASE = 224,
    parameter int unsigned SPD_W     = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sym_vld,
    input logic sdo,
    input logic busy,
    input logic ovr,
    input logic word_start
);
    localparam int unsigned MIN_WORD = WORD_BASE >> ((1 << SPD_W) - 1);
    localparam int unsigned CNT_W    = $clog2(WORD_BASE + 2);

    logic [CNT_W-1:0] since_q;
    logic             seen_q;

    // Counts cycles since the previous word start, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (word_start) begin
            since_q <= CNT_W'(1);
            seen_q  <= 1'b1;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdo);

    p_start_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sdo);

    p_slot_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && seen_q) |-> (since_q >= CNT_W'(MIN_WORD)));

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);

    p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(sym_vld));

endmodule

bind subcode_word_tx sctx_checker #(
    .WORD_BASE (WORD_BASE),
    .SPD_W     (SPD_W)
) u_sctx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_vld    (sym_vld),
    .sdo        (sdo),
    .busy       (busy),
    .ovr        (ovr),
    .word_start (fsm_pop)
);

// File: tb/test_subcode_word_tx.sv
module test_subcode_word_tx;
    localparam int CLK_PERIOD = 10;
    localparam int CELL_BASE  = 16;
    localparam int WORD_BASE  = 224;
    localparam int MAXW       = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_vld = 1'b0;
    logic [6:0] sym_bits = '0;
    logic       sym_sync = 1'b0;
    logic [1:0] spd = '0;
    logic       sdo, busy, ovr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Receiver model state
    int         mon_cnt = 0;
    int         mon_start [MAXW];
    logic [8:0] mon_cells [MAXW];
    int         cur_cell = CELL_BASE;
    logic       prev_sdo = 1'b0;
    bit         hunting = 1'b1;
    int         j = 0;

    subcode_word_tx #(
        .CELL_BASE (CELL_BASE),
        .WORD_BASE (WORD_BASE),
        .SPD_W     (2)
    ) i_subcode_word_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_vld  (sym_vld),
        .sym_bits (sym_bits),
        .sym_sync (sym_sync),
        .spd      (spd),
        .sdo      (sdo),
        .busy     (busy),
        .ovr      (ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Samples nine cell midpoints after each low-to-high start on the line
    always @(negedge clk) begin
        if (!rst_n) begin
            hunting  = 1'b1;
            prev_sdo = 1'b0;
        end else begin
            if (hunting) begin
                if (sdo && !prev_sdo && mon_cnt < MAXW) begin
                    hunting = 1'b0;
                    j = 0;
                    mon_start[mon_cnt] = cyc;
                    mon_cells[mon_cnt] = '0;
                end
            end else begin
                j++;
            end
            if (!hunting) begin
                if (j % cur_cell == cur_cell / 2)
                    mon_cells[mon_cnt][8 - j / cur_cell] = sdo;
                if (j == 9 * cur_cell - 1) begin
                    hunting = 1'b1;
                    mon_cnt++;
                end
            end
            prev_sdo = sdo;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic strobe(input logic [6:0] b, input logic s, output int c);
        @(negedge clk);
        c = cyc;
        sym_bits = b;
        sym_sync = s;
        sym_vld  = 1'b1;
        @(negedge clk);
        sym_vld  = 1'b0;
    endtask

    task automatic settle();
        repeat (3 * WORD_BASE) @(negedge clk);
    endtask

    function automatic logic [8:0] exp_word(input logic [6:0] b, input logic s);
        return s ? {1'b1, 1'b1, b} : {1'b1, b, 1'b0};
    endfunction

    task automatic t_reset();
        chk("R1 sdo after reset", int'(sdo), 0);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 ovr after reset", int'(ovr), 0);
    endtask

    task automatic t_single(input int s, input logic [6:0] b, input logic sy);
        int c0, base;
        spd = 2'(s);
        cur_cell = CELL_BASE >> s;
        base = mon_cnt;
        strobe(b, sy, c0);
        @(negedge clk);
        chk("R2 marker high at start", int'(sdo), 1);
        chk("R9 busy at start", int'(busy), 1);
        settle();
        chk("R2 one word sent", mon_cnt - base, 1);
        chk("R2 start latency", mon_start[base] - c0, 2);
        // Covers bit order (R3), cell length (R4) and marker length (R5)
        chk(sy ? "R5 sync word cells" : "R3 R4 word cells",
            int'(mon_cells[base]), int'(exp_word(b, sy)));
        chk("R6 line low after slot", int'(sdo), 0);
        chk("R9 busy low after slot", int'(busy), 0);
    endtask

    task automatic t_back2back(input int s);
        int c0, c1, base;
        spd = 2'(s);
        cur_cell = CELL_BASE >> s;
        base = mon_cnt;
        strobe(7'b1100101, 1'b0, c0);
        strobe(7'b0011010, 1'b1, c1);
        settle();
        chk("R7 two words sent", mon_cnt - base, 2);
        chk("R6 word spacing", mon_start[base + 1] - mon_start[base], WORD_BASE >> s);
        chk("R7 first word", int'(mon_cells[base]), int'(exp_word(7'b1100101, 1'b0)));
        chk("R7 held word", int'(mon_cells[base + 1]), int'(exp_word(7'b0011010, 1'b1)));
        chk("R8 no overrun", int'(ovr), 0);
    endtask

    task automatic t_overrun();
        int ca, cb, cc, base;
        spd = 2'd3;
        cur_cell = CELL_BASE >> 3;
        base = mon_cnt;
        strobe(7'b1010101, 1'b0, ca);
        strobe(7'b0110011, 1'b0, cb);
        chk("R8 no overrun before third", int'(ovr), 0);
        strobe(7'b1111111, 1'b0, cc);
        @(negedge clk);
        chk("R8 overrun raised", int'(ovr), 1);
        settle();
        chk("R8 dropped symbol not sent", mon_cnt - base, 2);
        chk("R8 held symbol kept", int'(mon_cells[base + 1]), int'(exp_word(7'b0110011, 1'b0)));
        chk("R8 overrun sticky", int'(ovr), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 overrun cleared by reset", int'(ovr), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int s = 0; s < 4; s++) t_single(s, 7'b0101101, 1'b0);
        for (int s = 0; s < 4; s++) t_single(s, 7'b0100011, 1'b1);
        for (int s = 0; s < 4; s++) t_back2back(s);
        t_overrun();
        summary();
        $finish;
    end

endmodule